// File: doc/BRIEF.md
# Capture/Compare Timer with Event Routing

This block is a 16-bit timer built around one shared up-counter and a parameterised set of channels. The counter advances on ticks from a power-of-two divider of the bus clock. It either runs through the whole 16-bit range, or it wraps after reaching a programmed limit. Each channel watches the counter and works in one of three ways. It can record the counter value when an input pin changes. It can act on its output pin when the counter reaches a stored value. It can produce a pulse-width waveform whose duty value is double-buffered.

Every event source has a sticky flag: the counter wrap and each channel. A per-source routing bit sends that flag either to an interrupt line for the processor or to a service-request line for a DMA engine, never to both. Software programs the block through a simple word-wide register port with a combinational read path. A DMA engine retires its requests with a one-cycle acknowledge pulse per source. Any channel can also invert its output on every counter wrap. Supported channel counts are 2, 6 and 8.

Top module: `cc_timer`

## Requirements
- R1: After reset the control word reads 0x0001 (counter halted, divide by 1, full-range mode, wrap routed to the processor). The limit reads 0xFFFF. The counter, the flags, all channel outputs, all interrupt lines and all request lines read zero.
- R2: In full-range mode (control bit 4 = 0), a tick with the counter at 0xFFFF takes it to 0 and sets the wrap flag (flag register bit 0).
- R3: In limit mode (control bit 4 = 1), a tick with the counter equal to the limit register (address 1) takes it to 0 and sets the wrap flag. Any other tick adds one.
- R4: Control bits 3:1 hold a divider selector s. The counter ticks once every 2^s bus cycles, and selector values 6 and 7 both divide by 64. Writing the counter (address 2) reloads it and restarts the division.
- R5: While control bit 0 (halt) is 1, the counter keeps its value. Halting does not clear it.
- R6: In compare mode (channel config bits 1:0 = 2), a tick with the counter equal to the channel value register sets the channel flag and applies the action in config bits 3:2 to the output: 1 sets it, 2 clears it, 3 inverts it, 0 leaves it alone.
- R7: In capture mode (mode 1), the input passes through two synchronising flip-flops. A selected edge then stores the current counter into the channel value register and sets the channel flag. Config bit 2 selects rising edges and bit 3 selects falling edges. An edge that is not selected changes neither the register nor the flag.
- R8: In waveform mode (mode 3), a wrap drives the output high and a match clears it. A wrap wins when both happen on one tick. A value written in this mode is readable at once, but it is used for matching only from the next wrap.
- R9: With config bit 4 set, a channel that is not in waveform mode inverts its output on every wrap, after any compare action of the same tick.
- R10: The routing bit (control bit 5 for the wrap, config bit 5 for a channel) sends a set flag to irq when it is 0 and to dma_req when it is 1. Bit 0 of both vectors is the wrap and bit i+1 is channel i.
- R11: Writing 1 to a bit of the flag register (address 3) clears that flag and writing 0 leaves it. A dma_ack pulse clears a flag only while that source is routed to DMA. A new event in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address: 0 control, 1 limit, 2 counter, 3 flags, 4+2i channel i config, 5+2i channel i value |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for reg_addr (combinational) |
| cap_in | input | NCH | Capture inputs, asynchronous |
| ch_out | output | NCH | Channel outputs |
| irq | output | NCH+1 | Processor interrupt requests, bit 0 wrap |
| dma_req | output | NCH+1 | DMA service requests, bit 0 wrap |
| dma_ack | input | NCH+1 | DMA acknowledge pulses, bit 0 wrap |

## Verification
The bound checker watches the counter on every cycle. It covers the wrap at the top of full range and at the programmed limit, and it checks that a halted counter holds. It also checks the forced-high output of a waveform channel at each wrap, and that a DMA acknowledge retires a pending request. Divider ratios, compare actions, capture edge selection, the deferred duty value, wrap toggling, and flag routing and clearing can only be shown by the bench. The bench runs directed scenarios and randomized limit, start, divider and channel settings, and compares against a tick-level model of the counter and channels.

// File: rtl/cct_pkg.sv
package cct_pkg;
    typedef enum logic [1:0] {
        CH_OFF = 2'd0,
        CH_CAP = 2'd1,
        CH_CMP = 2'd2,
        CH_PWM = 2'd3
    } ch_mode_e;

    // channel configuration word, bit 0 upward: mode, sel, toggle, route
    typedef struct packed {
        logic     route_dma;
        logic     tog_ovf;
        logic [1:0] sel;
        ch_mode_e mode;
    } ch_cfg_t;

    localparam int CFG_W  = $bits(ch_cfg_t);
    localparam int A_CTRL = 0;
    localparam int A_MOD  = 1;
    localparam int A_CNT  = 2;
    localparam int A_FLAG = 3;
    localparam int A_CH0  = 4;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int PSW = 6,
    localparam int SELW = $clog2(PSW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    typedef struct packed {
        logic [PSW-1:0] div;
    } psc_st_t;

    psc_st_t q, d;
    logic [PSW-1:0] mask;
    int sel_eff;

    always_comb begin
        sel_eff = (int'(sel) > PSW) ? PSW : int'(sel);
        mask    = {PSW{1'b1}} >> (PSW - sel_eff);
        tick    = run && ((q.div & mask) == mask);
        d       = q;
        if (restart) begin
            d.div = '0;
        end else if (run) begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          modulo,
    input  logic [CW-1:0] limit,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          ovf_evt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t q, d;
    logic [CW-1:0] top;

    always_comb begin
        top     = modulo ? limit : {CW{1'b1}};
        ovf_evt = tick && !load && (q.cnt == top);
        d       = q;
        if (load) begin
            d.cnt = load_val;
        end else if (tick) begin
            d.cnt = ovf_evt ? '0 : q.cnt + 1'b1;
        end
    end

    assign cnt = q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cct_channel.sv
module cct_channel import cct_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ch_cfg_t       cfg,
    input  logic          val_wr,
    input  logic [CW-1:0] wdata,
    input  logic          tick,
    input  logic          ovf_evt,
    input  logic [CW-1:0] cnt,
    input  logic          cap_in,
    input  logic          flag_clr,
    output logic [CW-1:0] val,
    output logic          flag,
    output logic          pin
);
    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] val;
        logic [CW-1:0] act;
        logic          pin;
        logic          flag;
    } ch_st_t;

    ch_st_t q, d;
    logic rise, fall, cap_hit, hit;
    logic [CW-1:0] cmp_ref;

    always_comb begin
        d       = q;
        d.sync  = {q.sync[1:0], cap_in};
        rise    = q.sync[1] && !q.sync[2];
        fall    = !q.sync[1] && q.sync[2];
        cap_hit = (cfg.mode == CH_CAP) && ((cfg.sel[0] && rise) || (cfg.sel[1] && fall));
        cmp_ref = (cfg.mode == CH_PWM) ? q.act : q.val;
        hit     = tick && (cnt == cmp_ref) &&
                  ((cfg.mode == CH_CMP) || (cfg.mode == CH_PWM));

        if (val_wr)  d.val = wdata;
        if (cap_hit) d.val = cnt;

        if ((cfg.mode != CH_PWM) || ovf_evt) d.act = q.val;

        case (cfg.mode)
            CH_CMP: begin
                if (hit) begin
                    case (cfg.sel)
                        2'd1:    d.pin = 1'b1;
                        2'd2:    d.pin = 1'b0;
                        2'd3:    d.pin = !q.pin;
                        default: d.pin = q.pin;
                    endcase
                end
                if (ovf_evt && cfg.tog_ovf) d.pin = !d.pin;
            end
            CH_PWM: begin
                if (ovf_evt)  d.pin = 1'b1;
                else if (hit) d.pin = 1'b0;
            end
            default: begin
                if (ovf_evt && cfg.tog_ovf) d.pin = !q.pin;
            end
        endcase

        if (flag_clr)       d.flag = 1'b0;
        if (hit || cap_hit) d.flag = 1'b1;
    end

    assign val  = q.val;
    assign flag = q.flag;
    assign pin  = q.pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer import cct_pkg::*; #(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int PSW = 6,
    localparam int AW   = $clog2(A_CH0 + 2 * NCH),
    localparam int SELW = $clog2(PSW + 1),
    localparam int NSRC = NCH + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [CW-1:0]   reg_wdata,
    output logic [CW-1:0]   reg_rdata,
    input  logic [NCH-1:0]  cap_in,
    output logic [NCH-1:0]  ch_out,
    output logic [NSRC-1:0] irq,
    output logic [NSRC-1:0] dma_req,
    input  logic [NSRC-1:0] dma_ack
);
    typedef struct packed {
        logic                 stop;
        logic [SELW-1:0]      psc;
        logic                 modulo;
        logic                 route;
        logic [CW-1:0]        limit;
        logic                 ovf_flag;
        ch_cfg_t [NCH-1:0]    cfg;
    } top_st_t;

    top_st_t q, d;

    logic            tick, ovf_evt, cnt_load, flag_wr;
    logic [CW-1:0]   cnt;
    logic [NCH-1:0]  val_wr, ch_clr, ch_flag;
    logic [CW-1:0]   ch_val [NCH];
    logic [NSRC-1:0] flags, route_vec;
    logic            stop_w, modulo_w, pwm0_w;
    logic [CW-1:0]   limit_w;

    assign cnt_load = reg_wr && (reg_addr == AW'(A_CNT));
    assign flag_wr  = reg_wr && (reg_addr == AW'(A_FLAG));

    always_comb begin
        d = q;
        if (reg_wr && (reg_addr == AW'(A_CTRL))) begin
            d.stop   = reg_wdata[0];
            d.psc    = reg_wdata[SELW:1];
            d.modulo = reg_wdata[SELW+1];
            d.route  = reg_wdata[SELW+2];
        end
        if (reg_wr && (reg_addr == AW'(A_MOD))) d.limit = reg_wdata;
        for (int i = 0; i < NCH; i++) begin
            if (reg_wr && (reg_addr == AW'(A_CH0 + 2 * i)))
                d.cfg[i] = ch_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
        if ((flag_wr && reg_wdata[0]) || (dma_ack[0] && q.route)) d.ovf_flag = 1'b0;
        if (ovf_evt) d.ovf_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.stop     <= 1'b1;
            q.limit    <= '1;
        end else begin
            q <= d;
        end
    end

    cct_prescaler #(.PSW(PSW)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!q.stop),
        .restart (cnt_load),
        .sel     (q.psc),
        .tick    (tick)
    );

    cct_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .modulo   (q.modulo),
        .limit    (q.limit),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign val_wr[g] = reg_wr && (reg_addr == AW'(A_CH0 + 2 * g + 1));
        assign ch_clr[g] = (flag_wr && reg_wdata[g+1]) ||
                           (dma_ack[g+1] && q.cfg[g].route_dma);
        assign route_vec[g+1] = q.cfg[g].route_dma;

        cct_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (q.cfg[g]),
            .val_wr   (val_wr[g]),
            .wdata    (reg_wdata),
            .tick     (tick),
            .ovf_evt  (ovf_evt),
            .cnt      (cnt),
            .cap_in   (cap_in[g]),
            .flag_clr (ch_clr[g]),
            .val      (ch_val[g]),
            .flag     (ch_flag[g]),
            .pin      (ch_out[g])
        );
    end

    assign route_vec[0] = q.route;
    assign flags        = {ch_flag, q.ovf_flag};
    assign irq          = flags & ~route_vec;
    assign dma_req      = flags & route_vec;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_CTRL): reg_rdata = CW'({q.route, q.modulo, q.psc, q.stop});
            AW'(A_MOD):  reg_rdata = q.limit;
            AW'(A_CNT):  reg_rdata = cnt;
            AW'(A_FLAG): reg_rdata = CW'(flags);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (reg_addr == AW'(A_CH0 + 2 * i))     reg_rdata = CW'(q.cfg[i]);
                    if (reg_addr == AW'(A_CH0 + 2 * i + 1)) reg_rdata = ch_val[i];
                end
            end
        endcase
    end

    assign stop_w   = q.stop;
    assign modulo_w = q.modulo;
    assign limit_w  = q.limit;
    assign pwm0_w   = (q.cfg[0].mode == CH_PWM);
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          ovf_evt,
    input logic          cnt_load,
    input logic          stopped,
    input logic          modulo,
    input logic [CW-1:0] limit,
    input logic [CW-1:0] cnt,
    input logic          pwm0,
    input logic          pin0,
    input logic          ack0,
    input logic          req0
);
    // R2
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !modulo && !cnt_load && (cnt == {CW{1'b1}})) |=> (cnt == '0));

    // R3
    limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && modulo && !cnt_load && (cnt == limit)) |=> (cnt == '0));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !cnt_load) |=> $stable(cnt));

    // R8
    wave_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && pwm0) |=> pin0);

    // R11
    ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack0 && req0 && !ovf_evt) |=> !req0);
endmodule

bind cc_timer cct_checker #(.CW(CW)) u_cct_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ovf_evt  (ovf_evt),
    .cnt_load (cnt_load),
    .stopped  (stop_w),
    .modulo   (modulo_w),
    .limit    (limit_w),
    .cnt      (cnt),
    .pwm0     (pwm0_w),
    .pin0     (ch_out[0]),
    .ack0     (dma_ack[0]),
    .req0     (dma_req[0])
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
    localparam int NCH = 8;
    localparam int AW  = 5;
    localparam int NS  = NCH + 1;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           reg_wr = 0;
    logic [AW-1:0]  reg_addr = '0;
    logic [15:0]    reg_wdata = '0;
    logic [15:0]    reg_rdata;
    logic [NCH-1:0] cap_in = '0;
    logic [NCH-1:0] ch_out;
    logic [NS-1:0]  irq, dma_req;
    logic [NS-1:0]  dma_ack = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // tick-level model state for channels 0..2
    logic [15:0] m_cnt, m_lim;
    bit m_modulo, m_route, m_ovf;
    int m_mode [3];
    int m_sel [3];
    bit m_tog [3];
    bit m_rt [3];
    logic [15:0] m_val [3];
    logic [15:0] m_act [3];
    bit m_out [3];
    bit m_flag [3];

    cc_timer u_cc_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
        .ch_out(ch_out), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack)
    );

    always #2 clk = ~clk;

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung act=running exp=finished");
        summary();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] v);
        @(negedge clk);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(int a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 v = reg_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(bit stop, int s);
        return {10'b0, m_route, m_modulo, 3'(s), stop};
    endfunction

    task automatic clear_flags();
        wr(3, 16'hFFFF);
        m_ovf = 0;
        for (int i = 0; i < 3; i++) m_flag[i] = 0;
    endtask

    task automatic load_cnt(logic [15:0] v);
        wr(2, v);
        m_cnt = v;
    endtask

    task automatic set_lim(logic [15:0] v);
        wr(1, v);
        m_lim = v;
    endtask

    task automatic set_ch(int i, int mode, int sel, bit tog, bit rt, logic [15:0] v);
        wr(4 + 2 * i, 16'h0);
        wr(5 + 2 * i, v);
        wr(4 + 2 * i, {10'b0, rt, tog, 2'(sel), 2'(mode)});
        m_mode[i] = mode; m_sel[i] = sel; m_tog[i] = tog; m_rt[i] = rt;
        m_val[i] = v; m_act[i] = v;
    endtask

    task automatic model_tick();
        logic [15:0] top;
        logic [15:0] cref;
        bit ov, hit;
        top = m_modulo ? m_lim : 16'hFFFF;
        ov = (m_cnt == top);
        for (int i = 0; i < 3; i++) begin
            cref = (m_mode[i] == 3) ? m_act[i] : m_val[i];
            hit = ((m_mode[i] == 2) || (m_mode[i] == 3)) && (m_cnt == cref);
            if (hit) m_flag[i] = 1;
            if (m_mode[i] == 2) begin
                if (hit) begin
                    if (m_sel[i] == 1) m_out[i] = 1;
                    else if (m_sel[i] == 2) m_out[i] = 0;
                    else if (m_sel[i] == 3) m_out[i] = !m_out[i];
                end
                if (ov && m_tog[i]) m_out[i] = !m_out[i];
            end else if (m_mode[i] == 3) begin
                if (ov) m_out[i] = 1;
                else if (hit) m_out[i] = 0;
                if (ov) m_act[i] = m_val[i];
            end else begin
                if (ov && m_tog[i]) m_out[i] = !m_out[i];
            end
        end
        m_cnt = ov ? 16'h0 : m_cnt + 16'h1;
        if (ov) m_ovf = 1;
    endtask

    // runs the counter for k+2 bus cycles at divider s, then halts
    task automatic run_ticks(int k, int s);
        int se;
        wr(0, ctrl_word(0, s));
        repeat (k) @(negedge clk);
        wr(0, ctrl_word(1, s));
        se = (s > 6) ? 6 : s;
        for (int t = 0; t < ((k + 2) >> se); t++) model_tick();
    endtask

    task automatic check_all(string tag);
        logic [15:0] v;
        logic [NS-1:0] ef, ei, ed;
        rd(2, v);
        chk({tag, " count"}, v, m_cnt);
        ef = '0; ei = '0; ed = '0;
        ef[0] = m_ovf;
        ei[0] = m_ovf && !m_route;
        ed[0] = m_ovf && m_route;
        for (int i = 0; i < 3; i++) begin
            ef[i+1] = m_flag[i];
            ei[i+1] = m_flag[i] && !m_rt[i];
            ed[i+1] = m_flag[i] && m_rt[i];
        end
        rd(3, v);
        chk({tag, " flags"}, v, 16'(ef));
        chk({tag, " outputs"}, ch_out, {5'b0, m_out[2], m_out[1], m_out[0]});
        chk({tag, " irq R10"}, irq, ei);
        chk({tag, " dma_req R10"}, dma_req, ed);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1357));
        m_cnt = 0; m_lim = 16'hFFFF; m_modulo = 0; m_route = 0; m_ovf = 0;
        for (int i = 0; i < 3; i++) begin
            m_mode[i] = 0; m_sel[i] = 0; m_tog[i] = 0; m_rt[i] = 0;
            m_val[i] = 0; m_act[i] = 0; m_out[i] = 0; m_flag[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, v); chk("R1 control", v, 16'h0001);
        rd(1, v); chk("R1 limit", v, 16'hFFFF);
        check_all("R1");

        // R5 halt keeps a loaded count
        load_cnt(16'h1234);
        repeat (20) @(negedge clk);
        rd(2, v); chk("R5 halted count", v, 16'h1234);

        // R2 full-range wrap
        clear_flags();
        load_cnt(16'hFFF0);
        run_ticks(20, 0);
        check_all("R2");

        // R11 write 0 keeps, write 1 clears
        wr(3, 16'h0000);
        rd(3, v); chk("R11 write-0 keeps", v, 16'h0001);
        wr(3, 16'h0001); m_ovf = 0;
        check_all("R11 write-1");

        // R4 every divider selector
        for (int s = 0; s < 8; s++) begin
            load_cnt(16'($urandom % 1000));
            run_ticks(10 + $urandom % 190, s);
            check_all("R4");
        end

        // R3 limit mode
        m_modulo = 1;
        clear_flags();
        set_lim(16'(20 + $urandom % 60));
        load_cnt(16'($urandom % 20));
        run_ticks(100, 0);
        check_all("R3");

        // R10 wrap to DMA, R11 acknowledge
        m_route = 1;
        clear_flags();
        set_lim(16'd9);
        load_cnt(16'd5);
        run_ticks(8, 0);
        check_all("R10 dma route");
        @(negedge clk); dma_ack[0] = 1;
        @(negedge clk); dma_ack[0] = 0;
        m_ovf = 0;
        check_all("R11 dma ack");
        m_route = 0;

        // R6 compare actions
        m_modulo = 0;
        clear_flags();
        set_ch(0, 2, 1, 0, 0, 16'd5);
        set_ch(1, 2, 3, 0, 0, 16'd7);
        set_ch(2, 2, 2, 0, 1, 16'd3);
        load_cnt(16'd0);
        run_ticks(8, 0);
        check_all("R6");

        // R9 toggle on wrap
        m_modulo = 1;
        clear_flags();
        set_lim(16'd9);
        set_ch(0, 2, 0, 1, 0, 16'd500);
        set_ch(1, 0, 0, 1, 0, 16'd0);
        set_ch(2, 0, 0, 0, 0, 16'd0);
        load_cnt(16'd0);
        run_ticks(33, 0);
        check_all("R9");

        // R8 waveform with deferred duty
        clear_flags();
        set_lim(16'd19);
        set_ch(0, 0, 0, 0, 0, 16'd0);
        set_ch(1, 3, 0, 0, 0, 16'd10);
        wr(5 + 2 * 1, 16'd4); m_val[1] = 16'd4;
        rd(5 + 2 * 1, v); chk("R8 value readback", v, 16'd4);
        load_cnt(16'd0);
        run_ticks(25, 0);
        check_all("R8");

        // R7 capture edges on channel 2
        clear_flags();
        load_cnt(16'h4321);
        set_ch(2, 1, 1, 0, 0, 16'd0);
        cap_in[2] = 1;
        repeat (5) @(negedge clk);
        rd(5 + 2 * 2, v); chk("R7 rising capture", v, 16'h4321);
        rd(3, v); chk("R7 capture flag", v[3], 1'b1);
        // R11 ack ignored while routed to processor
        @(negedge clk); dma_ack[3] = 1;
        @(negedge clk); dma_ack[3] = 0;
        chk("R11 ack ignored irq", irq[3], 1'b1);
        wr(3, 16'h0008);
        load_cnt(16'h1111);
        cap_in[2] = 0;
        repeat (5) @(negedge clk);
        rd(5 + 2 * 2, v); chk("R7 unselected edge value", v, 16'h4321);
        rd(3, v); chk("R7 unselected edge flag", v[3], 1'b0);
        wr(4 + 2 * 2, 16'h000D);
        load_cnt(16'h2222);
        cap_in[2] = 1;
        repeat (5) @(negedge clk);
        rd(5 + 2 * 2, v); chk("R7 both-edge capture", v, 16'h2222);
        clear_flags();
        set_ch(2, 0, 0, 0, 0, 16'd0);

        // randomized limit, start, divider and channel settings
        for (int it = 0; it < 40; it++) begin
            int lim;
            m_modulo = 1;
            m_route = bit'($urandom % 2);
            lim = 5 + $urandom % 40;
            clear_flags();
            set_lim(16'(lim));
            for (int c = 0; c < 3; c++) begin
                int md;
                md = $urandom % 3;
                md = (md == 0) ? 0 : md + 1;
                set_ch(c, md, $urandom % 4, bit'($urandom % 2), bit'($urandom % 2),
                       16'($urandom % (lim + 2)));
            end
            load_cnt(16'($urandom % (lim + 1)));
            run_ticks($urandom % 120, $urandom % 3);
            check_all("R6 R8 R9 R10 random");
        end

        summary();
    end
endmodule